// File: doc/BRIEF.md
# Panel Output Port Formatter

This block is the final stage in front of a display panel's pins. It takes a processed pixel stream with its DE, HS and VS timing and lays it out onto one or two pixel ports. In single-port mode each pixel leaves on port A, one pixel per clock. In dual-port mode the block pairs pixels. The first pixel of every active run is treated as even, and each even/odd pair leaves together, the even pixel on port A and the odd pixel on port B, at half the input rate. A data-clock line pulses once for each new output word.

Four output groups can each be switched off on their own: port A, port B, the control group (DE/HS/VS) and the data clock. A single select bit decides what a switched-off group does. It either keeps driving its pins low, or it releases them, which is signalled on that group's output-enable line. DE, HS, VS and the data clock each have their own polarity bit. The configuration is static-level input, and the enable, tri-state and polarity bits act on the outputs in the same cycle they change.

Top module: `panel_out_fmt`

## Requirements
- R1: After reset, with every group enabled, tri-state select 0 and all polarity bits 0, both port buses, DE, HS, VS and the data clock read 0, and all four output-enable lines read 1.
- R2: With the mode bit at 1 (single port), a pixel presented in one cycle appears on port A after the next rising clock edge, port B reads 0, and the data clock reads 1 in every cycle.
- R3: With the mode bit at 0 (dual port), the first pixel of each DE-high run is even. This holds whatever the number of blanking cycles that came before. After the edge that captures the odd pixel, port A shows the even pixel and port B the odd one, and both hold until the next pair is captured.
- R4: In dual mode the data clock is 1 only in the cycle in which a new pair appears, and 0 in the cycle after it.
- R5: DE, HS and VS are captured together with the data, so they reach the outputs with the same latency as the pixel they belong to.
- R6: A group whose enable bit is 0 drives every one of its outputs to 0, whatever its data or polarity bit.
- R7: The output-enable line of a group reads 0 only when that group is disabled and the tri-state select bit is 1; otherwise it reads 1.
- R8: When a group is enabled, the polarity bit of DE, HS, VS or the data clock set to 1 inverts that signal at the output.
- R9: Changes to the enable, tri-state select and polarity bits take effect at the outputs in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixIn | input | PIX_W | Incoming pixel |
| deIn | input | 1 | Incoming data enable, active high |
| hsIn | input | 1 | Incoming horizontal sync, active high |
| vsIn | input | 1 | Incoming vertical sync, active high |
| cfgSingle | input | 1 | Port layout: 1 single port, 0 dual port |
| cfgEnPortA | input | 1 | Port A output enable |
| cfgEnPortB | input | 1 | Port B output enable |
| cfgEnCtrl | input | 1 | DE/HS/VS group enable |
| cfgEnClk | input | 1 | Data clock enable |
| cfgTriSel | input | 1 | Disabled groups: 0 drive low, 1 release |
| cfgPolDe | input | 1 | Invert DE output |
| cfgPolVs | input | 1 | Invert VS output |
| cfgPolHs | input | 1 | Invert HS output |
| cfgPolClk | input | 1 | Invert data clock output |
| portAOut | output | PIX_W | Port A pixel bus (even pixels in dual mode) |
| portBOut | output | PIX_W | Port B pixel bus (odd pixels in dual mode) |
| deOut | output | 1 | Panel data enable |
| hsOut | output | 1 | Panel horizontal sync |
| vsOut | output | 1 | Panel vertical sync |
| dclkOut | output | 1 | Data clock strobe, one pulse per new output word |
| oePortA | output | 1 | Pad enable for port A |
| oePortB | output | 1 | Pad enable for port B |
| oeCtrl | output | 1 | Pad enable for DE/HS/VS |
| oeClk | output | 1 | Pad enable for the data clock |

## Verification
The pixel and timing results are due one edge after their capture cycle. In single mode that is the cycle the pixel is presented. In dual mode it is the odd pixel's cycle, so a pair is due one edge after its second pixel, and the data clock falls again one edge later. Enable, tri-state and polarity effects are due in the same cycle as the change. The bench drives every input on the falling clock edge and samples on the next falling edge. Each pixel result is therefore read exactly one rising edge after it was applied, and the gating checks are read before any further edge.

// File: rtl/pof_pkg.sv
package pof_pkg;
  // strobes from the pairing control to the datapath
  typedef struct packed {
    logic single;    // single-port layout in force
    logic loadEven;  // hold the current pixel as the even half of a pair
    logic capture;   // move data and timing into the output stage
  } pofStrobe_t;

  localparam int NUM_CTRL = 3; // DE, HS, VS
endpackage

// File: rtl/pof_ctrl.sv
module pof_ctrl
  import pof_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       deIn,
  input  logic       cfgSingle,
  output pofStrobe_t stb
);
  logic dePrev;
  logic lastEven;
  logic deRise;
  logic curEven;

  // a DE run always starts on an even pixel, otherwise the phase alternates
  assign deRise  = deIn & ~dePrev;
  assign curEven = deRise | ~lastEven;

  assign stb.single   = cfgSingle;
  assign stb.loadEven = ~cfgSingle & curEven;
  assign stb.capture  = cfgSingle | ~curEven;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dePrev   <= 1'b0;
      lastEven <= 1'b0;
    end else begin
      dePrev   <= deIn;
      lastEven <= curEven;
    end
  end

  // R4: in dual mode a capture is never followed by another capture
  a_r4_half_rate: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgSingle && stb.capture) |=> (cfgSingle || !stb.capture));

  // R3: the first pixel of a run is held as even, not captured
  a_r3_run_starts_even: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgSingle && deIn && !dePrev) |-> (stb.loadEven && !stb.capture));
endmodule

// File: rtl/pof_datapath.sv
module pof_datapath
  import pof_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  pofStrobe_t          stb,
  input  logic [PIX_W-1:0]    pixIn,
  input  logic [NUM_CTRL-1:0] ctrlIn,   // {vs, hs, de}
  input  logic                enPortA,
  input  logic                enPortB,
  input  logic                enCtrl,
  input  logic                enClk,
  input  logic                triSel,
  input  logic [NUM_CTRL-1:0] polCtrl,  // {vs, hs, de}
  input  logic                polClk,
  output logic [PIX_W-1:0]    portAOut,
  output logic [PIX_W-1:0]    portBOut,
  output logic [NUM_CTRL-1:0] ctrlOut,
  output logic                dclkOut,
  output logic                oePortA,
  output logic                oePortB,
  output logic                oeCtrl,
  output logic                oeClk
);
  logic [PIX_W-1:0]    evenReg;
  logic [PIX_W-1:0]    aReg;
  logic [PIX_W-1:0]    bReg;
  logic [NUM_CTRL-1:0] ctrlReg;
  logic                clkReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evenReg <= '0;
      aReg    <= '0;
      bReg    <= '0;
      ctrlReg <= '0;
      clkReg  <= 1'b0;
    end else begin
      clkReg <= stb.capture;
      if (stb.loadEven) evenReg <= pixIn;
      if (stb.capture) begin
        aReg    <= stb.single ? pixIn : evenReg;
        bReg    <= stb.single ? '0 : pixIn;
        ctrlReg <= ctrlIn;
      end
    end
  end

  // output gating: a disabled group drives 0, polarity only when enabled
  assign portAOut = enPortA ? aReg : '0;
  assign portBOut = enPortB ? bReg : '0;
  assign dclkOut  = enClk & (clkReg ^ polClk);

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
    assign ctrlOut[i] = enCtrl & (ctrlReg[i] ^ polCtrl[i]);
  end

  assign oePortA = enPortA | ~triSel;
  assign oePortB = enPortB | ~triSel;
  assign oeCtrl  = enCtrl  | ~triSel;
  assign oeClk   = enClk   | ~triSel;

  // R2: single mode puts the previous cycle's pixel on port A, port B idle
  a_r2_single_path: assert property (@(posedge clk) disable iff (!rstN)
    stb.single |=> (aReg == $past(pixIn) && bReg == '0));

  // R3: a dual-mode pair holds the two pixels presented before the strobe
  a_r3_pair_order: assert property (@(posedge clk) disable iff (!rstN)
    (clkReg && $past(!stb.single) && $past(!stb.single, 2))
      |-> (aReg == $past(pixIn, 2) && bReg == $past(pixIn)));

  // R7: with drive-low selected every pad stays enabled
  a_r7_drive_low_keeps_oe: assert property (@(posedge clk) disable iff (!rstN)
    !triSel |-> (oePortA && oePortB && oeCtrl && oeClk));

  // R6: a disabled port never shows data
  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!enPortA |-> portAOut == '0) and (!enClk |-> !dclkOut));
endmodule

// File: rtl/panel_out_fmt.sv
module panel_out_fmt
  import pof_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIX_W-1:0] pixIn,
  input  logic             deIn,
  input  logic             hsIn,
  input  logic             vsIn,
  input  logic             cfgSingle,
  input  logic             cfgEnPortA,
  input  logic             cfgEnPortB,
  input  logic             cfgEnCtrl,
  input  logic             cfgEnClk,
  input  logic             cfgTriSel,
  input  logic             cfgPolDe,
  input  logic             cfgPolVs,
  input  logic             cfgPolHs,
  input  logic             cfgPolClk,
  output logic [PIX_W-1:0] portAOut,
  output logic [PIX_W-1:0] portBOut,
  output logic             deOut,
  output logic             hsOut,
  output logic             vsOut,
  output logic             dclkOut,
  output logic             oePortA,
  output logic             oePortB,
  output logic             oeCtrl,
  output logic             oeClk
);
  pofStrobe_t          stb;
  logic [NUM_CTRL-1:0] ctrlOut;

  pof_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .deIn      (deIn),
    .cfgSingle (cfgSingle),
    .stb       (stb)
  );

  pof_datapath #(.PIX_W(PIX_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .pixIn    (pixIn),
    .ctrlIn   ({vsIn, hsIn, deIn}),
    .enPortA  (cfgEnPortA),
    .enPortB  (cfgEnPortB),
    .enCtrl   (cfgEnCtrl),
    .enClk    (cfgEnClk),
    .triSel   (cfgTriSel),
    .polCtrl  ({cfgPolVs, cfgPolHs, cfgPolDe}),
    .polClk   (cfgPolClk),
    .portAOut (portAOut),
    .portBOut (portBOut),
    .ctrlOut  (ctrlOut),
    .dclkOut  (dclkOut),
    .oePortA  (oePortA),
    .oePortB  (oePortB),
    .oeCtrl   (oeCtrl),
    .oeClk    (oeClk)
  );

  assign deOut = ctrlOut[0];
  assign hsOut = ctrlOut[1];
  assign vsOut = ctrlOut[2];
endmodule

// File: tb/panel_out_fmt_tb.sv
module panel_out_fmt_tb;
  localparam int PIX_W = 24;

  logic             clk = 1'b0;
  logic             rstN;
  logic [PIX_W-1:0] pixIn;
  logic             deIn, hsIn, vsIn;
  logic             cfgSingle, cfgEnPortA, cfgEnPortB, cfgEnCtrl, cfgEnClk;
  logic             cfgTriSel, cfgPolDe, cfgPolVs, cfgPolHs, cfgPolClk;
  logic [PIX_W-1:0] portAOut, portBOut;
  logic             deOut, hsOut, vsOut, dclkOut;
  logic             oePortA, oePortB, oeCtrl, oeClk;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk; // 50 MHz

  panel_out_fmt #(.PIX_W(PIX_W)) u_dut (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // called at a falling edge: apply inputs, wait through one rising edge
  task automatic step(input logic [PIX_W-1:0] p, input logic d,
                      input logic h, input logic v);
    pixIn = p; deIn = d; hsIn = h; vsIn = v;
    @(negedge clk);
  endtask

  task automatic defaults();
    cfgEnPortA = 1; cfgEnPortB = 1; cfgEnCtrl = 1; cfgEnClk = 1;
    cfgTriSel = 0; cfgPolDe = 0; cfgPolVs = 0; cfgPolHs = 0; cfgPolClk = 0;
  endtask

  task automatic testReset();
    chk("R1", "portA", portAOut, 0);
    chk("R1", "portB", portBOut, 0);
    chk("R1", "de/hs/vs", {deOut, hsOut, vsOut}, 0);
    chk("R1", "dclk", dclkOut, 0);
    chk("R1", "oe", {oePortA, oePortB, oeCtrl, oeClk}, 4'hf);
  endtask

  task automatic testSingle();
    cfgSingle = 1;
    step(24'h112233, 1, 0, 0);
    chk("R2", "portA", portAOut, 24'h112233);
    chk("R2", "portB", portBOut, 0);
    chk("R2", "dclk", dclkOut, 1);
    chk("R5", "de", deOut, 1);
    step(24'h445566, 1, 1, 0);
    chk("R2", "portA next", portAOut, 24'h445566);
    chk("R2", "dclk next", dclkOut, 1);
    chk("R5", "hs", hsOut, 1);
    step(24'h000000, 0, 0, 1);
    chk("R5", "de low vs high", {deOut, vsOut}, 2'b01);
  endtask

  task automatic testDual();
    cfgSingle = 0;
    step(0, 0, 0, 0);
    step(24'hA00000, 1, 0, 0);
    chk("R4", "dclk on even", dclkOut, 0);
    step(24'hA00001, 1, 1, 0);
    chk("R3", "portA even", portAOut, 24'hA00000);
    chk("R3", "portB odd", portBOut, 24'hA00001);
    chk("R4", "dclk on pair", dclkOut, 1);
    chk("R5", "de/hs with pair", {deOut, hsOut}, 2'b11);
    step(24'hA00002, 1, 0, 0);
    chk("R4", "dclk after pair", dclkOut, 0);
    chk("R3", "portA held", portAOut, 24'hA00000);
    chk("R3", "portB held", portBOut, 24'hA00001);
    step(24'hA00003, 1, 0, 0);
    chk("R3", "second pair A", portAOut, 24'hA00002);
    chk("R3", "second pair B", portBOut, 24'hA00003);
    step(24'hA00004, 1, 0, 0);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    // free-running phase would now call this pixel odd; a new run must not
    step(24'hB00000, 1, 0, 0);
    chk("R3", "realign dclk", dclkOut, 0);
    step(24'hB00001, 1, 0, 0);
    chk("R3", "realign A", portAOut, 24'hB00000);
    chk("R3", "realign B", portBOut, 24'hB00001);
    chk("R4", "realign dclk pair", dclkOut, 1);
    step(0, 0, 0, 0);
    cfgSingle = 1;
    step(0, 0, 0, 0);
  endtask

  task automatic testGate();
    defaults();
    cfgSingle = 1;
    step(24'h5A5A5A, 1, 1, 1);
    cfgEnPortA = 0; cfgTriSel = 1;
    #1;
    chk("R6", "portA disabled", portAOut, 0);
    chk("R7", "oeA released", oePortA, 0);
    chk("R7", "oeB enabled", oePortB, 1);
    chk("R9", "portB same cycle", portBOut, 0);
    cfgTriSel = 0;
    #1;
    chk("R7", "oeA drive low", oePortA, 1);
    chk("R6", "portA driven low", portAOut, 0);
    cfgEnCtrl = 0; cfgEnClk = 0; cfgTriSel = 1; cfgPolDe = 1; cfgPolClk = 1;
    #1;
    chk("R6", "ctrl disabled", {deOut, hsOut, vsOut}, 0);
    chk("R6", "dclk disabled", dclkOut, 0);
    chk("R7", "oe ctrl/clk", {oeCtrl, oeClk}, 0);
    cfgEnPortA = 1;
    #1;
    chk("R9", "portA re-enabled", portAOut, 24'h5A5A5A);
    defaults();
  endtask

  task automatic testPol();
    defaults();
    cfgSingle = 1;
    cfgPolDe = 1; cfgPolHs = 1; cfgPolVs = 1; cfgPolClk = 1;
    step(24'h0F0F0F, 1, 0, 1);
    chk("R8", "de/hs/vs inverted", {deOut, hsOut, vsOut}, 3'b010);
    chk("R8", "dclk inverted", dclkOut, 0);
    step(24'h0F0F0F, 0, 1, 0);
    chk("R8", "de/hs/vs inverted 2", {deOut, hsOut, vsOut}, 3'b101);
    cfgPolHs = 0;
    #1;
    chk("R9", "hs polarity same cycle", hsOut, 1);
    defaults();
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    defaults();
    cfgSingle = 1;
    rstN = 0; pixIn = 0; deIn = 0; hsIn = 0; vsIn = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testSingle();
    testDual();
    testGate();
    testPol();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule